// File: doc/BRIEF.md
# Magnitude Threshold Comparator with Persistence Counter

This block watches a stream of signed 24-bit conversion results. It compares the magnitude of each result, taken as an unsigned number, against a programmable threshold. It raises a single-cycle interrupt pulse when the configured condition is met. A 2-bit mode input selects one of four behaviours:

- **Off.** Nothing happens.
- **Immediate.** Every qualifying sample fires the interrupt.
- **Persistence, clear on miss.** The condition must hold for a programmed number of conversions. A sample under the threshold zeroes the progress.
- **Persistence, decrement on miss.** As above, except that a sample under the threshold takes back one step of progress.

The block sits next to a converter's result path. The sample-valid strobe marks each new result. The threshold and the required count come from configuration registers held elsewhere. The running persistence count is brought out as an output so that it can be observed.

Top module: `mag_thresh_persist`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `irq` is 0 and `hit_cnt` is 0.
- R2: With `mode` = 2'b00 (off), `irq` stays 0 and `hit_cnt` stays 0 whatever the samples are.
- R3: With `mode` = 2'b01 (immediate), a valid sample whose magnitude is greater than or equal to `thresh` produces `irq` = 1. A valid sample below `thresh` produces `irq` = 0. `hit_cnt` stays 0.
- R4: `sample` is two's complement and `thresh` is unsigned. The magnitude of 24'h800000 is 8388608, so that value meets a threshold of 24'h800000, while 24'h7FFFFF does not.
- R5: In mode 2'b10 or 2'b11, a valid qualifying sample advances `hit_cnt` by one. When the advanced value reaches the target count, `irq` pulses and `hit_cnt` returns to 0.
- R6: In mode 2'b10, a valid sample below `thresh` sets `hit_cnt` to 0.
- R7: In mode 2'b11, a valid sample below `thresh` lowers `hit_cnt` by one, and a count of 0 stays at 0.
- R8: A `need_cnt` of 0 acts as a target of 1.
- R9: On a cycle with `smp_vld` low and `mode` unchanged, `irq` is 0 on the next cycle and `hit_cnt` keeps its value.
- R10: A cycle on which `mode` differs from its value on the previous cycle clears the count. A valid sample on that same cycle is evaluated from a count of 0 under the new mode. The mode held during reset counts as 2'b00.
- R11: `irq` and `hit_cnt` are registered. Both reflect a sample on the clock edge that ends its valid cycle, and `irq` stays high for exactly one cycle per firing sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 off, 01 immediate, 10 persist/clear, 11 persist/decrement |
| smp_vld | input | 1 | Marks a new conversion result on `sample` |
| sample | input | 24 | Signed conversion result |
| thresh | input | 24 | Unsigned magnitude threshold |
| need_cnt | input | 16 | Required number of qualifying conversions |
| irq | output | 1 | Interrupt pulse |
| hit_cnt | output | 16 | Current persistence count |

## Verification
The most negative sample is driven against the largest threshold. A magnitude path kept at 24 bits would wrap that value to a small or negative number and miss the interrupt.

Long mixed sequences cover each counting mode and a count target of 0 to 4:

- A clear-on-miss policy in the decrement mode would drop the count to 0 instead of by one.
- A decrement without a floor would wrap the count to 65535.
- A target of 0 handled literally would never fire, or would fire one sample late.

Mode switches in the middle of a count, and idle cycles, catch designs that keep stale progress or that move the count when no sample is valid.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

    localparam int SAMPLE_W = 24;
    localparam int COUNT_W  = 16;

    typedef enum logic [1:0] {
        CMP_OFF     = 2'b00,
        CMP_IMM     = 2'b01,
        CMP_CNT_CLR = 2'b10,
        CMP_CNT_DEC = 2'b11
    } cmp_mode_e;

    typedef struct packed {
        logic vld;
        logic hit;
    } cmp_ev_t;

    function automatic logic is_count_mode(cmp_mode_e m);
        return (m == CMP_CNT_CLR) || (m == CMP_CNT_DEC);
    endfunction

endpackage

// File: rtl/mtp_mag_cmp.sv
module mtp_mag_cmp
    import mtp_pkg::*;
#(
    parameter int SW = SAMPLE_W
) (
    input  logic          vld,
    input  logic [SW-1:0] sample,
    input  logic [SW-1:0] thresh,
    output cmp_ev_t       ev
);
    localparam int MW = SW + 1;

    logic [MW-1:0] ext;
    logic [MW-1:0] mag;

    always_comb begin
        ext = {sample[SW-1], sample};
        mag = ext[MW-1] ? (~ext + {{(MW-1){1'b0}}, 1'b1}) : ext;
        ev.vld = vld;
        ev.hit = (mag >= {1'b0, thresh});
    end
endmodule

// File: rtl/mtp_mode_track.sv
module mtp_mode_track
    import mtp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic [1:0] mode,
    output cmp_mode_e cur,
    output logic      changed
);
    cmp_mode_e prev_q;

    always_comb begin
        cur     = cmp_mode_e'(mode);
        changed = (cur != prev_q);
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= CMP_OFF;
        else     prev_q <= cur;
    end
endmodule

// File: rtl/mtp_persist.sv
module mtp_persist
    import mtp_pkg::*;
#(
    parameter int CW = COUNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  cmp_mode_e     md,
    input  logic          changed,
    input  cmp_ev_t       ev,
    input  logic [CW-1:0] need,
    output logic          irq,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] cnt_q, base, tgt, nxt;
    logic [CW:0]   inc;
    logic          fire, irq_q;

    always_comb begin
        base = changed ? '0 : cnt_q;
        tgt  = (need == '0) ? {{(CW-1){1'b0}}, 1'b1} : need;
        inc  = {1'b0, base} + {{CW{1'b0}}, 1'b1};
        nxt  = base;
        fire = 1'b0;
        if (ev.vld) begin
            unique case (md)
                CMP_OFF: nxt = '0;
                CMP_IMM: begin
                    nxt  = '0;
                    fire = ev.hit;
                end
                CMP_CNT_CLR, CMP_CNT_DEC: begin
                    if (ev.hit) begin
                        if (inc >= {1'b0, tgt}) begin
                            fire = 1'b1;
                            nxt  = '0;
                        end else begin
                            nxt = inc[CW-1:0];
                        end
                    end else if (md == CMP_CNT_CLR) begin
                        nxt = '0;
                    end else begin
                        nxt = (base == '0) ? '0 : base - {{(CW-1){1'b0}}, 1'b1};
                    end
                end
                default: nxt = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            cnt_q <= is_count_mode(md) ? nxt : '0;
            irq_q <= fire;
        end
    end

    assign cnt = cnt_q;
    assign irq = irq_q;
endmodule

// File: rtl/mag_thresh_persist.sv
module mag_thresh_persist
    import mtp_pkg::*;
#(
    parameter int SW = SAMPLE_W,
    parameter int CW = COUNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    input  logic          smp_vld,
    input  logic [SW-1:0] sample,
    input  logic [SW-1:0] thresh,
    input  logic [CW-1:0] need_cnt,
    output logic          irq,
    output logic [CW-1:0] hit_cnt
);
    cmp_ev_t   ev;
    cmp_mode_e md;
    logic      md_chg;

    mtp_mag_cmp #(.SW(SW)) u_cmp (
        .vld(smp_vld), .sample(sample), .thresh(thresh), .ev(ev)
    );

    mtp_mode_track u_mode (
        .clk(clk), .rst(rst), .mode(mode), .cur(md), .changed(md_chg)
    );

    mtp_persist #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .md(md), .changed(md_chg), .ev(ev),
        .need(need_cnt), .irq(irq), .cnt(hit_cnt)
    );
endmodule

// File: rtl/mag_thresh_persist_chk.sv
module mag_thresh_persist_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    mode,
    input logic          smp_vld,
    input logic          irq,
    input logic [CW-1:0] hit_cnt
);
    logic [1:0] md_d;
    logic       vld_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            md_d  <= 2'b00;
            vld_d <= 1'b0;
        end else begin
            md_d  <= mode;
            vld_d <= smp_vld;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!irq && hit_cnt == '0)); // R1
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst) (mode == 2'b00) |=> (!irq && hit_cnt == '0)); // R2
    AST_IMM_NO_COUNT: assert property (@(posedge clk) disable iff (rst) (mode == 2'b01) |=> (hit_cnt == '0)); // R3
    AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst) (mode == 2'b11 && md_d == 2'b11 && smp_vld) |=> (hit_cnt == '0 || hit_cnt == $past(hit_cnt) + 1'b1 || hit_cnt == $past(hit_cnt) - 1'b1)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!smp_vld && mode == md_d) |=> ($stable(hit_cnt) && !irq)); // R9
    AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (rst) (mode != md_d && !smp_vld) |=> (hit_cnt == '0)); // R10
    AST_FIRE_RESTART: assert property (@(posedge clk) disable iff (rst) irq |-> (hit_cnt == '0 && vld_d)); // R11
endmodule

bind mag_thresh_persist mag_thresh_persist_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .mode(mode), .smp_vld(smp_vld), .irq(irq), .hit_cnt(hit_cnt)
);

// File: tb/mag_thresh_persist_bench.sv
module mag_thresh_persist_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic        smp_vld = 1'b0;
    logic [23:0] sample = '0;
    logic [23:0] thresh = '0;
    logic [15:0] need_cnt = '0;
    logic        irq;
    logic [15:0] hit_cnt;

    int checks = 0;
    int errors = 0;

    int          m_pm = 0;
    int          m_cnt = 0;
    logic [31:0] lfsr = 32'h1ACE_B00F;

    always #10 clk = ~clk;

    mag_thresh_persist u_mag_thresh_persist (
        .clk(clk), .rst(rst), .mode(mode), .smp_vld(smp_vld), .sample(sample),
        .thresh(thresh), .need_cnt(need_cnt), .irq(irq), .hit_cnt(hit_cnt)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Called at a falling edge: applies inputs, predicts, checks at next falling edge.
    task automatic cyc(input int m, input bit v, input logic [23:0] s);
        longint sv, mag;
        int base, tgt, nc;
        bit hit, chg, e_irq;
        string tag;
        mode = m[1:0]; smp_vld = v; sample = s;
        sv  = longint'($signed(s));
        mag = (sv < 0) ? -sv : sv;
        hit = (mag >= longint'(thresh));
        chg = (m != m_pm);
        base = chg ? 0 : m_cnt;
        tgt  = (need_cnt == 0) ? 1 : int'(need_cnt);
        nc = base; e_irq = 1'b0;
        if (v) begin
            if (m == 0) nc = 0;
            else if (m == 1) begin nc = 0; e_irq = hit; end
            else if (hit) begin
                if (base + 1 >= tgt) begin e_irq = 1'b1; nc = 0; end
                else nc = base + 1;
            end else if (m == 2) nc = 0;
            else nc = (base == 0) ? 0 : base - 1;
        end
        if (m < 2) nc = 0;
        if (chg) tag = "R10";
        else if (!v) tag = "R9";
        else if (m == 0) tag = "R2";
        else if (m == 1) tag = (mag >= 64'd8388607) ? "R4" : "R3";
        else if (need_cnt == 0) tag = "R8";
        else if (hit) tag = "R5";
        else tag = (m == 2) ? "R6" : "R7";
        m_pm = m; m_cnt = nc;
        @(negedge clk);
        chk(e_irq ? "R11 irq" : {tag, " irq"}, int'(irq), int'(e_irq));
        chk({tag, " hit_cnt"}, int'(hit_cnt), nc);
    endtask

    function automatic logic [23:0] next_sample(input logic [31:0] r);
        int k;
        k = int'(r[11:4] % 8'd19);
        if (k == 17) return 24'h800000;
        if (k == 18) return 24'h7FFFFF;
        return 24'(k - 8);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 irq", int'(irq), 0);
        chk("R1 hit_cnt", int'(hit_cnt), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 irq after release", int'(irq), 0);
        chk("R1 hit_cnt after release", int'(hit_cnt), 0);

        // Sweep: every mode, targets 0..4, two thresholds, mixed valid/idle.
        for (int th = 0; th < 2; th++) begin
            thresh = (th == 0) ? 24'd5 : 24'd1;
            for (int md = 0; md < 4; md++) begin
                for (int nd = 0; nd < 5; nd++) begin
                    need_cnt = 16'(nd);
                    for (int i = 0; i < 40; i++) begin
                        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                        cyc(md, (lfsr[2:0] != 3'd0), next_sample(lfsr));
                    end
                end
            end
        end

        // Extreme magnitude against the largest threshold (R4).
        thresh = 24'h800000; need_cnt = 16'd1;
        cyc(1, 1'b1, 24'h800000);
        cyc(1, 1'b1, 24'h7FFFFF);
        cyc(1, 1'b1, 24'h800001);
        cyc(1, 1'b0, 24'h800000);

        // Decrement floor and mode-change clearing (R7, R10).
        thresh = 24'd3; need_cnt = 16'd5;
        cyc(3, 1'b1, 24'd4);
        cyc(3, 1'b1, -24'sd9);
        cyc(3, 1'b1, 24'd3);
        cyc(3, 1'b1, 24'd1);
        cyc(3, 1'b1, 24'd0);
        cyc(3, 1'b1, 24'd0);
        cyc(3, 1'b1, 24'd7);
        cyc(3, 1'b1, 24'd7);
        cyc(2, 1'b0, 24'd7);
        cyc(2, 1'b1, 24'd7);
        cyc(3, 1'b1, 24'd7);
        cyc(0, 1'b1, 24'd7);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule